// File: doc/BRIEF.md
# PWM Timer with Grouped Compare Update

This block is one up-counting timer that drives three waveform channels, A, B and D. The counter starts at zero, climbs to a programmable ceiling and wraps. The clock on which it wraps closes one PWM cycle. Each channel compares its own value against the counter. Software writes the ceiling and the three compare values through a small address/data port. Every write first lands in a staging register. All staged values, the ceiling included, become active together on a wrap.

A hold control can freeze that handover. While it is set, writes keep collecting in the staging registers and nothing active changes. When it is cleared, the whole collected set takes effect at the next wrap. Several duties can therefore be retuned without a PWM cycle that mixes old and new settings.

In waveform mode each channel produces a non-inverted, inverted or complementary pulse train. In match mode a channel instead sets, clears or toggles its output when the counter equals its compare value. A fine-step option gives each counter step two clock phases. The compare LSB then acts as a half-step, so the duty can be placed halfway between two ordinary settings.

Top module: `pwm_lock_timer`

## Requirements
- R1: While `rst` is high, both output buses are low. Reset clears the counter, every staging register and every active register.
- R2: The counter runs from 0 up to the active ceiling and then wraps to 0. One PWM cycle is ceiling+1 clocks, or 2*(ceiling+1) clocks with `fine_mode` set.
- R3: `wr_addr` selects the target: 0 is channel A, 1 is channel B, 2 is channel D and 3 is the ceiling. A write changes only the staging register, and active values change only on the wrap clock.
- R4: While `hold` is high, active values do not change, for any number of PWM cycles.
- R5: After `hold` falls, all staged values load on the same wrap, so every channel switches to its new duty on the same clock.
- R6: In waveform mode (`pwm_mode`=1) a channel with compare C is high for min(C, ceiling+1) clocks of each cycle. The per-channel 2-bit mode selects the outputs: 00 drives both low; 01 gives that pulse on `wave_out` with `wave_out_n` low; 10 gives its inverse on `wave_out` with `wave_out_n` low; 11 gives the pulse on `wave_out` and its inverse on `wave_out_n`.
- R7: With `fine_mode`=1 in waveform mode, a compare C means a value of C>>1 plus a half-step in C[0]. The high time is min(C, 2*(ceiling+1)) clocks of the 2*(ceiling+1)-clock cycle. For example, C=0x85 with ceiling 127 gives 133/256.
- R8: In match mode (`pwm_mode`=0), `wave_out_n` stays low. On a match, mode 01 toggles `wave_out`, 10 clears it and 11 sets it; mode 00 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write target: A, B, D, ceiling |
| wr_data | input | 8 | Write data |
| hold | input | 1 | Freeze handover of staged values |
| pwm_mode | input | 1 | 1 = waveform mode, 0 = match mode |
| fine_mode | input | 1 | Half-step resolution |
| out_mode | input | 6 | 2-bit output mode per channel, channel i in bits [2i+1:2i] |
| wave_out | output | 3 | Main waveform per channel (bit 0 = A, 1 = B, 2 = D) |
| wave_out_n | output | 3 | Complementary waveform per channel |

## Verification
The in-RTL assertions check several properties on every clock. The counter never passes the ceiling and returns to zero after a wrap. Active registers move only on a wrap, and never while held. A complementary pair always disagrees, match mode keeps `wave_out_n` low, and a clear action lowers the output. Only the bench scenarios can show the rest. These are measured duty counts in both resolutions and in every output mode, the absence of any new duty across several held cycles, and that all three channels take their new duty on exactly the same clock after release.

// File: rtl/pwm_lock_timer_pkg.sv
`timescale 1ns/1ps
package pwm_lock_timer_pkg;

    // per-channel output mode codes
    localparam logic [1:0] OM_IDLE  = 2'b00; // PWM: both low   | match: no action
    localparam logic [1:0] OM_PRIME = 2'b01; // PWM: true pulse | match: toggle
    localparam logic [1:0] OM_INV   = 2'b10; // PWM: inverted   | match: clear
    localparam logic [1:0] OM_PAIR  = 2'b11; // PWM: true + inv | match: set

    typedef struct packed {
        logic main;
        logic comp;
    } wave_pair_t;

    function automatic wave_pair_t pwm_shape(input logic [1:0] mode, input logic below);
        wave_pair_t w;
        w = '0;
        case (mode)
            OM_PRIME: w.main = below;
            OM_INV:   w.main = !below;
            OM_PAIR:  begin
                w.main = below;
                w.comp = !below;
            end
            default:  w = '0;
        endcase
        return w;
    endfunction

    function automatic logic match_action(input logic [1:0] mode, input logic hit, input logic cur);
        logic nxt;
        nxt = cur;
        if (hit) begin
            case (mode)
                OM_PRIME: nxt = !cur;
                OM_INV:   nxt = 1'b0;
                OM_PAIR:  nxt = 1'b1;
                default:  nxt = cur;
            endcase
        end
        return nxt;
    endfunction

endpackage

// File: rtl/pwm_step_counter.sv
`timescale 1ns/1ps
module pwm_step_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fine_mode,
    input  logic [CNT_W-1:0] ceiling,
    output logic [CNT_W-1:0] cnt,
    output logic             phase,
    output logic             wrap
);

    assign wrap = (cnt == ceiling) && (!fine_mode || phase);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (wrap) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (fine_mode && !phase) begin
            phase <= 1'b1;
        end else begin
            cnt   <= cnt + 1'b1;
            phase <= 1'b0;
        end
    end

    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= ceiling);

    // R2
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (rst)
        wrap |=> (cnt == '0) && !phase);

endmodule

// File: rtl/pwm_shadow_bank.sv
`timescale 1ns/1ps
module pwm_shadow_bank #(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 3,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [CNT_W-1:0]              wr_data,
    input  logic                          hold,
    input  logic                          wrap,
    output logic [NUM_CH-1:0][CNT_W-1:0]  act_cmp,
    output logic [CNT_W-1:0]              act_top
);

    logic [NUM_CH-1:0][CNT_W-1:0] stg_cmp;
    logic [CNT_W-1:0]             stg_top;
    logic                         commit;

    assign commit = wrap && !hold;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_cmp <= '0;
            stg_top <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_CH; i++) begin
                if (wr_addr == ADDR_W'(i)) stg_cmp[i] <= wr_data;
            end
            if (wr_addr == ADDR_W'(NUM_CH)) stg_top <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            act_cmp <= '0;
            act_top <= '0;
        end else if (commit) begin
            act_cmp <= stg_cmp;
            act_top <= stg_top;
        end
    end

    // R4
    held_stable_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(act_cmp) && $stable(act_top));

    // R3
    load_on_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(act_cmp) && $stable(act_top));

endmodule

// File: rtl/pwm_wave_channel.sv
`timescale 1ns/1ps
module pwm_wave_channel
    import pwm_lock_timer_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwm_mode,
    input  logic             fine_mode,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cnt,
    input  logic             phase,
    input  logic [CNT_W-1:0] cmp,
    output logic             wave,
    output logic             wave_n
);

    logic [CNT_W:0] pos;
    logic [CNT_W:0] ref_pos;
    logic           below;
    logic           hit;
    wave_pair_t     shaped;

    always_comb begin
        pos     = {cnt, fine_mode & phase};
        ref_pos = fine_mode ? {1'b0, cmp} : {cmp, 1'b0};
        below   = pos < ref_pos;
        hit     = pos == ref_pos;
        shaped  = pwm_shape(mode, below);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wave   <= 1'b0;
            wave_n <= 1'b0;
        end else if (pwm_mode) begin
            wave   <= shaped.main;
            wave_n <= shaped.comp;
        end else begin
            wave   <= match_action(mode, hit, wave);
            wave_n <= 1'b0;
        end
    end

    // R6
    pair_differs_chk: assert property (@(posedge clk) disable iff (rst)
        (pwm_mode && mode == OM_PAIR) |=> (wave != wave_n));

    // R8
    match_comp_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pwm_mode |=> !wave_n);

    // R8
    match_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (!pwm_mode && mode == OM_INV && hit) |=> !wave);

endmodule

// File: rtl/pwm_lock_timer.sv
`timescale 1ns/1ps
module pwm_lock_timer
    import pwm_lock_timer_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int NUM_CH = 3,
    localparam int ADDR_W = $clog2(NUM_CH + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [CNT_W-1:0]      wr_data,
    input  logic                  hold,
    input  logic                  pwm_mode,
    input  logic                  fine_mode,
    input  logic [2*NUM_CH-1:0]   out_mode,
    output logic [NUM_CH-1:0]     wave_out,
    output logic [NUM_CH-1:0]     wave_out_n
);

    logic [NUM_CH-1:0][CNT_W-1:0] act_cmp;
    logic [CNT_W-1:0]             act_top;
    logic [CNT_W-1:0]             cnt;
    logic                         phase;
    logic                         wrap;

    pwm_step_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .fine_mode (fine_mode),
        .ceiling   (act_top),
        .cnt       (cnt),
        .phase     (phase),
        .wrap      (wrap)
    );

    pwm_shadow_bank #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_bank (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .hold    (hold),
        .wrap    (wrap),
        .act_cmp (act_cmp),
        .act_top (act_top)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pwm_wave_channel #(.CNT_W(CNT_W)) u_ch (
            .clk       (clk),
            .rst       (rst),
            .pwm_mode  (pwm_mode),
            .fine_mode (fine_mode),
            .mode      (out_mode[2*g +: 2]),
            .cnt       (cnt),
            .phase     (phase),
            .cmp       (act_cmp[g]),
            .wave      (wave_out[g]),
            .wave_n    (wave_out_n[g])
        );
    end

    // R1
    reset_outputs_low_chk: assert property (@(posedge clk)
        rst |=> (wave_out == '0) && (wave_out_n == '0));

endmodule

// File: tb/pwm_lock_timer_test.sv
`timescale 1ns/1ps
module pwm_lock_timer_test;
    localparam int CW = 8;
    localparam int NC = 3;
    localparam int AW = 2;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [CW-1:0] wr_data = '0;
    logic hold = 1'b0;
    logic pwm_mode = 1'b1;
    logic fine_mode = 1'b0;
    logic [2*NC-1:0] out_mode = '0;
    logic [NC-1:0] wave_out;
    logic [NC-1:0] wave_out_n;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;
    int hi_o[NC];
    int hi_n[NC];

    always #2.5 clk = ~clk;

    pwm_lock_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hold(hold), .pwm_mode(pwm_mode), .fine_mode(fine_mode), .out_mode(out_mode),
        .wave_out(wave_out), .wave_out_n(wave_out_n)
    );

    function automatic int period_of(input int top, input bit fine);
        return fine ? 2 * (top + 1) : top + 1;
    endfunction

    function automatic int high_of(input int c, input int top, input bit fine);
        int p;
        p = period_of(top, fine);
        return (c < p) ? c : p;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = AW'(a);
        wr_data = CW'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic measure(input int cyc);
        for (int i = 0; i < NC; i++) begin
            hi_o[i] = 0;
            hi_n[i] = 0;
        end
        repeat (cyc) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) begin
                hi_o[i] += int'(wave_out[i]);
                hi_n[i] += int'(wave_out_n[i]);
            end
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int run[NC];
        int maxrun[NC];
        int first[NC];
        int top, c[NC], m[NC], p, b;
        bit fine;
        void'($urandom(32'h5eed));

        // R1: outputs low during reset even with inverted mode requested
        out_mode = {2'b10, 2'b10, 2'b10};
        settle(4);
        check("R1 wave_out in reset", int'(wave_out), 0);
        check("R1 wave_out_n in reset", int'(wave_out_n), 0);
        @(negedge clk);
        rst = 1'b0;
        out_mode = '0;

        // R3 R6: unheld writes, true pulse, ceiling 9 (address 3)
        wr(3, 9); wr(0, 2); wr(1, 5); wr(2, 12);
        out_mode = {2'b01, 2'b01, 2'b01};
        settle(40);
        measure(20);
        check("R3 R6 A high per 2 periods", hi_o[0], 4);
        check("R3 R6 B high per 2 periods", hi_o[1], 10);
        check("R6 D capped high", hi_o[2], 20);

        // R6: inverted, complementary, idle
        out_mode = {2'b00, 2'b11, 2'b10};
        settle(5);
        measure(20);
        check("R6 A inverted", hi_o[0], 16);
        check("R6 B complementary main", hi_o[1], 10);
        check("R6 B complementary inv", hi_n[1], 10);
        check("R6 D idle main", hi_o[2], 0);
        check("R6 D idle inv", hi_n[2], 0);
        check("R6 A inverted comp low", hi_n[0], 0);

        // R4 R5: hold group update
        out_mode = {2'b01, 2'b01, 2'b01};
        wr(0, 2); wr(1, 2); wr(2, 2);
        settle(40);
        @(negedge clk);
        hold = 1'b1;
        wr(0, 6); wr(1, 5); wr(2, 7);
        for (int i = 0; i < NC; i++) begin run[i] = 0; maxrun[i] = 0; hi_o[i] = 0; end
        for (int t = 0; t < 80; t++) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) begin
                hi_o[i] += int'(wave_out[i]);
                run[i] = wave_out[i] ? run[i] + 1 : 0;
                if (run[i] > maxrun[i]) maxrun[i] = run[i];
            end
        end
        for (int i = 0; i < NC; i++) begin
            check("R4 held high count", hi_o[i], 16);
            check("R4 held max run", maxrun[i], 2);
        end
        hold = 1'b0;
        for (int i = 0; i < NC; i++) begin run[i] = 0; first[i] = -1; end
        for (int t = 0; t < 40; t++) begin
            @(negedge clk);
            for (int i = 0; i < NC; i++) begin
                run[i] = wave_out[i] ? run[i] + 1 : 0;
                if (run[i] == 3 && first[i] < 0) first[i] = t;
            end
        end
        check("R5 A switched after release", int'(first[0] >= 0), 1);
        check("R5 B same clock as A", first[1], first[0]);
        check("R5 D same clock as A", first[2], first[0]);
        measure(20);
        check("R5 A new duty", hi_o[0], 12);
        check("R5 B new duty", hi_o[1], 10);
        check("R5 D new duty", hi_o[2], 14);

        // R7: half-step, ceiling 127
        fine_mode = 1'b1;
        wr(3, 127); wr(0, 8'h85); wr(1, 8'h84); wr(2, 8'h86);
        settle(600);
        measure(256);
        check("R7 A 0x85 half-step", hi_o[0], 133);
        check("R7 B 0x84", hi_o[1], 132);
        check("R7 D 0x86", hi_o[2], 134);

        // R8: match mode actions, ceiling 9
        fine_mode = 1'b0;
        pwm_mode = 1'b0;
        wr(3, 9); wr(0, 3); wr(1, 4); wr(2, 5);
        out_mode = {2'b10, 2'b11, 2'b01};
        settle(600);
        measure(20);
        check("R8 toggle", hi_o[0], 10);
        check("R8 set", hi_o[1], 20);
        check("R8 clear", hi_o[2], 0);
        check("R8 comp low", hi_n[0] + hi_n[1] + hi_n[2], 0);
        out_mode = {2'b10, 2'b00, 2'b01};
        measure(20);
        check("R8 no action keeps high", hi_o[1], 20);

        // R2 R6 R7: random configurations
        pwm_mode = 1'b1;
        for (int k = 0; k < 12; k++) begin
            top = 3 + int'($urandom % 38);
            fine = $urandom % 2;
            p = period_of(top, fine);
            fine_mode = fine;
            wr(3, top);
            for (int i = 0; i < NC; i++) begin
                c[i] = int'($urandom % (p + 4));
                if (c[i] > 255) c[i] = 255;
                m[i] = int'($urandom % 4);
                wr(i, c[i]);
                out_mode[2*i +: 2] = 2'(m[i]);
            end
            settle(200);
            measure(p);
            for (int i = 0; i < NC; i++) begin
                b = high_of(c[i], top, fine);
                case (m[i])
                    0: begin check("R6 rand idle", hi_o[i], 0); check("R6 rand idle n", hi_n[i], 0); end
                    1: begin check("R2 R7 rand true", hi_o[i], b); check("R6 rand true n", hi_n[i], 0); end
                    2: begin check("R2 R7 rand inverted", hi_o[i], p - b); check("R6 rand inv n", hi_n[i], 0); end
                    default: begin check("R2 R7 rand pair", hi_o[i], b); check("R6 rand pair n", hi_n[i], p - b); end
                endcase
            end
        end

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule